// File: doc/BRIEF.md
# HDLC Serial Frame Receiver

This block takes one HDLC channel as a serial bit stream, qualified by a per-bit enable so that it can sit behind a TDM time-slot demultiplexer and only advance on its own slot. It hunts for the 01111110 flag, removes the zero stuffed after every five data ones, recognises aborts, checks the frame check sequence with the CRC-CCITT polynomial x^16 + x^12 + x^5 + 1, and packs the unstuffed bits into octets.

Each finished octet, including the two FCS octets, is placed on an 8-bit bus with a one-clock active-low data strobe. When a frame closes on a flag, or an abort cuts it short, a status byte is placed on the same bus one clock later with its own one-clock active-low strobe. A raw 8-bit window holds back the newest bits so that no part of a closing flag ever leaves as data.

The receiver is a three-state machine. HUNT waits for a flag (reset state; also entered after any run of seven ones). ALIGN counts eight enabled bits after a flag while the window refills; HUNT to ALIGN on a flag, ALIGN to ALIGN on a further flag (counter restarts), ALIGN to HUNT on seven ones, ALIGN to DATA when the eighth bit arrives. DATA passes the oldest window bit into destuffing, CRC and packing on every enabled bit; DATA to ALIGN on a flag (status written), DATA to HUNT on seven ones (abort status written).

Top module: `hdlc_frame_rx`

## Requirements
- R1: After reset, and after any run of seven or more ones, no output is produced until the pattern 01111110 has been seen on eight consecutive enabled bits.
- R2: Flags that follow each other with no data between them, including two flags sharing one zero (011111101111110), produce no data and no status.
- R3: Inside a frame, a 0 that follows five consecutive data 1s is dropped and does not count as a data bit.
- R4: Bits arrive least significant first; every eight kept bits form an octet that appears on `rx_byte` with `data_wr_n` low for exactly one clock, the clock after the edge that took the octet's last bit; the FCS octets are delivered the same way.
- R5: No bit of a closing flag is delivered as data; the status byte appears with `stat_wr_n` low for exactly one clock, in the clock after the one that carries any final data strobe, and the two strobes are never low together.
- R6: Status bit 0 is set when the CRC over all kept bits (register preset to 0xFFFF, processed least significant bit first) does not end at the residue 0xF0B8.
- R7: Status bit 1 is set when the number of kept bits in the frame is not a multiple of eight.
- R8: Seven consecutive ones while in DATA end the frame with status byte 0x04 (bit 2 = abort); seven ones in ALIGN end it silently.
- R9: While `bit_en` is low all receiver state is frozen and `rx_bit` is ignored; no data strobe follows a clock with `bit_en` low.
- R10: During and after reset both strobes are high and `rx_byte` is 0x00; `rx_byte` only changes together with a strobe.
- R11: Status bits 7 to 3 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Qualifies `rx_bit` for this channel's slot |
| rx_bit | input | 1 | Serial line bit |
| rx_byte | output | 8 | Received octet or status byte |
| data_wr_n | output | 1 | Active-low one-clock strobe: `rx_byte` is data |
| stat_wr_n | output | 1 | Active-low one-clock strobe: `rx_byte` is status |

## Verification
Plain frames of arbitrary octets show octet order, bit order and the FCS pass-through, while frames full of 0xFF, 0x7E and 0x1F force stuffed zeros next to flag-like runs and separate correct destuffing from a receiver that lets flags escape. Shared-zero and back-to-back flags tell the flag-restart path apart from real data, a corrupted FCS and a frame padded with three extra bits isolate the two status error bits, and an abort followed by an idle line and a new frame shows both the abort status and the return to hunting. The same frame played with random disabled slots carrying junk on the line shows that only enabled bits advance the receiver.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    localparam int OCTET_W = 8;
    localparam logic [OCTET_W-1:0] FLAG_PAT = 8'h7E;

    localparam int STAT_CRC = 0;
    localparam int STAT_OCT = 1;
    localparam int STAT_ABT = 2;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_ALIGN,
        ST_DATA
    } rx_state_t;
endpackage

// File: rtl/hdlc_rx_linewatch.sv
// Raw line window: flag match, run-of-ones abort detection, delayed bit out.
module hdlc_rx_linewatch
    import hdlc_rx_pkg::*;
#(
    parameter int ABORT_RUN = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic flag_hit,
    output logic abort_hit,
    output logic exit_bit
);
    localparam int RUN_W = $clog2(ABORT_RUN + 1);

    logic [OCTET_W-1:0] win;
    logic [OCTET_W-1:0] win_nxt;
    logic [RUN_W-1:0]   run;

    always_comb begin
        win_nxt   = {din, win[OCTET_W-1:1]};
        flag_hit  = en && (win_nxt == FLAG_PAT);
        abort_hit = en && din && (run == RUN_W'(ABORT_RUN - 1));
        exit_bit  = win[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
            run <= '0;
        end else if (en) begin
            win <= win_nxt;
            if (!din)
                run <= '0;
            else if (run != RUN_W'(ABORT_RUN))
                run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/hdlc_rx_destuff.sv
// Drops the zero that follows a run of data ones.
module hdlc_rx_destuff #(
    parameter int STUFF_RUN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  logic din,
    output logic keep
);
    localparam int ONES_W = $clog2(STUFF_RUN + 2);

    logic [ONES_W-1:0] ones;

    assign keep = step && !(!din && (ones == ONES_W'(STUFF_RUN)));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ones <= '0;
        end else if (step) begin
            if (!din)
                ones <= '0;
            else if (ones != ONES_W'(STUFF_RUN + 1))
                ones <= ones + 1'b1;
        end
    end
endmodule

// File: rtl/hdlc_rx_fcs.sv
// Reflected CRC checker, least significant bit first.
module hdlc_rx_fcs #(
    parameter int          CRC_W    = 16,
    parameter logic [15:0] CRC_POLY = 16'h8408,
    parameter logic [15:0] CRC_INIT = 16'hFFFF,
    parameter logic [15:0] CRC_GOOD = 16'hF0B8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic shift,
    input  logic din,
    output logic good_nxt
);
    logic [CRC_W-1:0] crc;
    logic [CRC_W-1:0] crc_nxt;

    always_comb begin
        crc_nxt = {1'b0, crc[CRC_W-1:1]};
        if (crc[0] ^ din)
            crc_nxt = crc_nxt ^ CRC_POLY[CRC_W-1:0];
        good_nxt = ((shift ? crc_nxt : crc) == CRC_GOOD[CRC_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            crc <= CRC_INIT[CRC_W-1:0];
        else if (shift)
            crc <= crc_nxt;
    end
endmodule

// File: rtl/hdlc_rx_octet.sv
// Packs kept bits into octets, least significant bit first.
module hdlc_rx_octet
    import hdlc_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               shift,
    input  logic               din,
    output logic               oct_done,
    output logic [OCTET_W-1:0] oct_val,
    output logic               part_nxt
);
    localparam int CNT_W = $clog2(OCTET_W);

    logic [OCTET_W-1:0] sr;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cnt_nxt;

    always_comb begin
        oct_val  = {din, sr[OCTET_W-1:1]};
        oct_done = shift && (cnt == CNT_W'(OCTET_W - 1));
        if (!shift)
            cnt_nxt = cnt;
        else if (cnt == CNT_W'(OCTET_W - 1))
            cnt_nxt = '0;
        else
            cnt_nxt = cnt + 1'b1;
        part_nxt = (cnt_nxt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr  <= '0;
            cnt <= '0;
        end else if (shift) begin
            sr  <= oct_val;
            cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
    import hdlc_rx_pkg::*;
#(
    parameter int          STUFF_RUN = 5,
    parameter int          ABORT_RUN = 7,
    parameter logic [15:0] CRC_POLY  = 16'h8408,
    parameter logic [15:0] CRC_INIT  = 16'hFFFF,
    parameter logic [15:0] CRC_GOOD  = 16'hF0B8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  logic               rx_bit,
    output logic [OCTET_W-1:0] rx_byte,
    output logic               data_wr_n,
    output logic               stat_wr_n
);
    localparam int SKIP_W = $clog2(OCTET_W);

    rx_state_t          state, state_nxt;
    logic [SKIP_W-1:0]  skip, skip_nxt;
    logic               flag_hit, abort_hit, exit_bit;
    logic               step, keep, clr;
    logic               good_nxt, part_nxt, oct_done;
    logic [OCTET_W-1:0] oct_val;
    logic               end_frame;
    logic [OCTET_W-1:0] end_code;
    logic               stat_pend;
    logic [OCTET_W-1:0] stat_code;

    assign step = bit_en && (state == ST_DATA);
    assign clr  = flag_hit || abort_hit;

    hdlc_rx_linewatch #(.ABORT_RUN(ABORT_RUN)) u_line (
        .clk(clk), .rst(rst), .en(bit_en), .din(rx_bit),
        .flag_hit(flag_hit), .abort_hit(abort_hit), .exit_bit(exit_bit)
    );

    hdlc_rx_destuff #(.STUFF_RUN(STUFF_RUN)) u_destuff (
        .clk(clk), .rst(rst), .clr(clr), .step(step), .din(exit_bit),
        .keep(keep)
    );

    hdlc_rx_fcs #(
        .CRC_W(16), .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT), .CRC_GOOD(CRC_GOOD)
    ) u_fcs (
        .clk(clk), .rst(rst), .clr(clr), .shift(keep), .din(exit_bit),
        .good_nxt(good_nxt)
    );

    hdlc_rx_octet u_octet (
        .clk(clk), .rst(rst), .clr(clr), .shift(keep), .din(exit_bit),
        .oct_done(oct_done), .oct_val(oct_val), .part_nxt(part_nxt)
    );

    // Next-state and frame-end decision.
    always_comb begin
        state_nxt = state;
        skip_nxt  = skip;
        end_frame = 1'b0;
        end_code  = '0;
        if (bit_en) begin
            unique case (state)
                ST_HUNT: begin
                    if (flag_hit) begin
                        state_nxt = ST_ALIGN;
                        skip_nxt  = '0;
                    end
                end
                ST_ALIGN: begin
                    if (abort_hit) begin
                        state_nxt = ST_HUNT;
                    end else if (flag_hit) begin
                        skip_nxt = '0;
                    end else begin
                        skip_nxt = skip + 1'b1;
                        if (skip == SKIP_W'(OCTET_W - 1))
                            state_nxt = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (abort_hit) begin
                        state_nxt           = ST_HUNT;
                        end_frame           = 1'b1;
                        end_code[STAT_ABT]  = 1'b1;
                    end else if (flag_hit) begin
                        state_nxt           = ST_ALIGN;
                        skip_nxt            = '0;
                        end_frame           = 1'b1;
                        end_code[STAT_CRC]  = !good_nxt;
                        end_code[STAT_OCT]  = part_nxt;
                    end
                end
                default: state_nxt = ST_HUNT;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HUNT;
            skip  <= '0;
        end else begin
            state <= state_nxt;
            skip  <= skip_nxt;
        end
    end

    // Output register: data strobe on octet completion, status one clock after frame end.
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte   <= '0;
            data_wr_n <= 1'b1;
            stat_wr_n <= 1'b1;
            stat_pend <= 1'b0;
            stat_code <= '0;
        end else begin
            data_wr_n <= !oct_done;
            stat_wr_n <= !stat_pend;
            stat_pend <= end_frame;
            if (end_frame)
                stat_code <= end_code;
            if (oct_done)
                rx_byte <= oct_val;
            else if (stat_pend)
                rx_byte <= stat_code;
        end
    end
endmodule

// File: rtl/hdlc_frame_rx_chk.sv
module hdlc_frame_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic [7:0] rx_byte,
    input logic       data_wr_n,
    input logic       stat_wr_n
);
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(!data_wr_n && !stat_wr_n));

    assert_data_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        !data_wr_n |=> data_wr_n);

    assert_stat_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        !stat_wr_n |=> stat_wr_n);

    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !stat_wr_n |-> (rx_byte[7:3] == 5'd0));

    assert_frozen_no_data_R9: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> data_wr_n);

    assert_bus_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_byte) |-> (!data_wr_n || !stat_wr_n));
endmodule

bind hdlc_frame_rx hdlc_frame_rx_chk i_chk (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_byte(rx_byte),
    .data_wr_n(data_wr_n), .stat_wr_n(stat_wr_n)
);

// File: tb/test_hdlc_frame_rx.sv
module test_hdlc_frame_rx;
    logic       clk = 1'b0;
    logic       rst;
    logic       bit_en;
    logic       rx_bit;
    logic [7:0] rx_byte;
    logic       data_wr_n;
    logic       stat_wr_n;

    always #10 clk = ~clk;

    hdlc_frame_rx i_hdlc_frame_rx (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
        .rx_byte(rx_byte), .data_wr_n(data_wr_n), .stat_wr_n(stat_wr_n)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R10";

    // Behavioural reference state.
    int       m_mode = 0;
    bit       m_q[$];
    int       m_dones = 0;
    int       m_crc = 'hFFFF;
    int       m_nbits = 0;
    int       m_acc = 0;
    bit [7:0] m_raw = 8'h00;
    int       m_run = 0;
    bit       stat_due = 0;
    int       stat_val_due = 0;

    // Observed per scenario.
    logic [7:0] got_bytes[$];
    int         got_stats[$];

    // Stimulus construction.
    bit         strm[$];
    logic [7:0] pay[$];
    int         st_ones = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_bit(input bit b, output bit bev, output int bval,
                             output bit sev, output int sval);
        bit popped = 0;
        bev = 0; bval = 0; sev = 0; sval = 0;
        if (m_mode == 1 && m_q.size() == 8) begin
            bit e;
            e = m_q.pop_front();
            popped = 1;
            if (e == 0 && m_dones == 5) begin
                m_dones = 0;
            end else begin
                m_dones = e ? m_dones + 1 : 0;
                if (((m_crc ^ int'(e)) & 1) != 0) m_crc = (m_crc >> 1) ^ 'h8408;
                else m_crc = m_crc >> 1;
                m_acc = ((m_acc >> 1) | (int'(e) << 7)) & 255;
                m_nbits++;
                if (m_nbits % 8 == 0) begin bev = 1; bval = m_acc; end
            end
        end
        if (m_mode == 1) m_q.push_back(b);
        m_raw = {b, m_raw[7:1]};
        m_run = b ? m_run + 1 : 0;
        if (m_run == 7) begin
            if (popped) begin sev = 1; sval = 4; end
            m_mode = 0;
            m_q.delete();
        end else if (m_raw == 8'h7E) begin
            if (popped) begin
                sev  = 1;
                sval = ((m_crc != 'hF0B8) ? 1 : 0) | ((m_nbits % 8 != 0) ? 2 : 0);
            end
            m_mode = 1;
            m_q.delete();
            m_dones = 0; m_crc = 'hFFFF; m_nbits = 0;
        end
    endtask

    // One clock: drive at negedge, compare at the following negedge.
    task automatic tick(input bit b, input bit en);
        bit bev, sev;
        int bval, sval;
        bev = 0; sev = 0; bval = 0; sval = 0;
        rx_bit = b;
        bit_en = en;
        if (en) model_bit(b, bev, bval, sev, sval);
        @(posedge clk);
        @(negedge clk);
        check(data_wr_n == !bev, cur_req, data_wr_n, !bev);
        if (bev) check(rx_byte == bval[7:0], cur_req, rx_byte, bval);
        check(stat_wr_n == !stat_due, cur_req, stat_wr_n, !stat_due);
        if (stat_due) check(rx_byte == stat_val_due[7:0], cur_req, rx_byte, stat_val_due);
        if (!data_wr_n) got_bytes.push_back(rx_byte);
        if (!stat_wr_n) got_stats.push_back(int'(rx_byte));
        stat_due = sev;
        stat_val_due = sval;
    endtask

    task automatic add_flag();
        strm.push_back(0);
        repeat (6) strm.push_back(1);
        strm.push_back(0);
    endtask

    task automatic put_stuffed(input bit b);
        strm.push_back(b);
        if (b) begin
            st_ones++;
            if (st_ones == 5) begin strm.push_back(0); st_ones = 0; end
        end else begin
            st_ones = 0;
        end
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int k = 0; k < 8; k++) put_stuffed(v[k]);
    endtask

    // Frame body from pay[], FCS appended low byte first, optional corruption and padding.
    task automatic add_frame(input bit corrupt, input int pad);
        int c = 'hFFFF;
        logic [15:0] fcs;
        st_ones = 0;
        foreach (pay[i]) begin
            for (int k = 0; k < 8; k++) begin
                if (((c ^ int'(pay[i][k])) & 1) != 0) c = (c >> 1) ^ 'h8408;
                else c = c >> 1;
            end
            put_byte(pay[i]);
        end
        fcs = ~c[15:0];
        if (corrupt) fcs[3] = ~fcs[3];
        put_byte(fcs[7:0]);
        put_byte(fcs[15:8]);
        for (int k = 0; k < pad; k++) put_stuffed(k[0]);
    endtask

    task automatic play(input bit gapped);
        foreach (strm[i]) begin
            if (gapped && ($urandom % 3 == 0)) begin
                int g = 1 + int'($urandom % 3);
                for (int j = 0; j < g; j++) tick(1'($urandom % 2), 0);
            end
            tick(strm[i], 1);
        end
        strm.delete();
        for (int j = 0; j < 4; j++) tick(0, 0);
    endtask

    task automatic new_scenario(input string req);
        cur_req = req;
        got_bytes.delete();
        got_stats.delete();
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; bit_en = 1'b0; rx_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(data_wr_n == 1'b1, "R10", data_wr_n, 1);
        check(stat_wr_n == 1'b1, "R10", stat_wr_n, 1);
        check(rx_byte == 8'h00, "R10", rx_byte, 0);

        // R1: idle ones while hunting give nothing; R2: empty and shared-zero flags give nothing
        new_scenario("R1");
        repeat (20) strm.push_back(1);
        add_flag(); add_flag();
        repeat (6) strm.push_back(1);
        strm.push_back(0);
        add_flag();
        play(0);
        check(got_bytes.size() == 0, "R2", got_bytes.size(), 0);
        check(got_stats.size() == 0, "R2", got_stats.size(), 0);

        // R4/R5/R6: plain good frame
        new_scenario("R4");
        pay = '{8'h12, 8'h34, 8'h56};
        add_flag(); add_frame(0, 0); add_flag();
        play(0);
        check(got_bytes.size() == 5, "R5", got_bytes.size(), 5);
        if (got_bytes.size() >= 3) begin
            check(got_bytes[0] == 8'h12, "R4", got_bytes[0], 8'h12);
            check(got_bytes[2] == 8'h56, "R4", got_bytes[2], 8'h56);
        end
        check(got_stats.size() == 1 && got_stats[0] == 0, "R6",
              got_stats.size() > 0 ? got_stats[0] : -1, 0);

        // R3: stuffing-heavy frame
        new_scenario("R3");
        pay = '{8'hFF, 8'h7E, 8'hF8, 8'h1F, 8'hFF};
        add_flag(); add_frame(0, 0); add_flag();
        play(0);
        check(got_bytes.size() == 7, "R3", got_bytes.size(), 7);
        if (got_bytes.size() >= 2) check(got_bytes[1] == 8'h7E, "R3", got_bytes[1], 8'h7E);
        check(got_stats.size() == 1 && got_stats[0] == 0, "R3",
              got_stats.size() > 0 ? got_stats[0] : -1, 0);

        // R2: two frames separated by flags sharing one zero
        new_scenario("R2");
        pay = '{8'hA5, 8'h00};
        add_flag(); add_frame(0, 0);
        add_flag();
        repeat (6) strm.push_back(1);
        strm.push_back(0);
        pay = '{8'h3C};
        add_frame(0, 0); add_flag();
        play(0);
        check(got_stats.size() == 2, "R2", got_stats.size(), 2);
        check(got_bytes.size() == 7, "R2", got_bytes.size(), 7);

        // R6: corrupted FCS
        new_scenario("R6");
        pay = '{8'hC3, 8'h81};
        add_flag(); add_frame(1, 0); add_flag();
        play(0);
        check(got_stats.size() == 1 && got_stats[0] == 1, "R6",
              got_stats.size() > 0 ? got_stats[0] : -1, 1);

        // R7/R11: three extra bits before the closing flag
        new_scenario("R7");
        pay = '{8'h55, 8'hAA};
        add_flag(); add_frame(0, 3); add_flag();
        play(0);
        check(got_stats.size() == 1 && (got_stats[0] & 2) != 0, "R7",
              got_stats.size() > 0 ? got_stats[0] : -1, 2);
        check(got_stats.size() == 1 && (got_stats[0] & 'hF8) == 0, "R11",
              got_stats.size() > 0 ? got_stats[0] : -1, 0);

        // R8: abort mid-frame, idle ones, then a fresh good frame
        new_scenario("R8");
        pay = '{8'h11, 8'h22, 8'h33};
        add_flag();
        st_ones = 0;
        foreach (pay[i]) put_byte(pay[i]);
        repeat (20) strm.push_back(1);
        pay = '{8'h44};
        add_flag(); add_frame(0, 0); add_flag();
        play(0);
        check(got_stats.size() == 2, "R8", got_stats.size(), 2);
        if (got_stats.size() == 2) begin
            check(got_stats[0] == 4, "R8", got_stats[0], 4);
            check(got_stats[1] == 0, "R8", got_stats[1], 0);
        end

        // R9: slot gaps with junk on the line
        new_scenario("R9");
        pay = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
        add_flag(); add_frame(0, 0); add_flag();
        play(1);
        check(got_bytes.size() == 6, "R9", got_bytes.size(), 6);
        if (got_bytes.size() >= 4) check(got_bytes[3] == 8'hEF, "R9", got_bytes[3], 8'hEF);
        check(got_stats.size() == 1 && got_stats[0] == 0, "R9",
              got_stats.size() > 0 ? got_stats[0] : -1, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule